// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block gathers interrupt events from a set of DMA channel engines and presents them to a host processor through a small register window. Each engine reports an event as a one-cycle pulse on one of four class inputs, tagged with its channel number. The four classes are whole-chain completion, single-node (or cyclic period) completion, and two independent error classes. Every class keeps one sticky raw bit per channel and one enable mask bit per channel.

The host reads masked per-class views, which are the raw bits gated by the enables. It also reads a combined per-channel summary that is set when any class has an enabled pending event for that channel. It acknowledges events by writing a one-hot or multi-bit pattern to a class's raw register, which clears the chosen bits. A single registered interrupt line goes high while any combined bit is set.

The register port is a plain valid/write/address/data interface. Read data returns one cycle after the request.

Top module: `dia_irq_agg`

## Requirements
- R1: While reset is high, and after it is released, all raw bits and all mask bits are zero. `irq_o` and `rd_vld_o` are low, and `rd_data_o` is zero.
- R2: A pulse on `evt_vld_i[c]` with channel index `evt_ch_i[c]` sets raw bit [index] of class c at that clock edge, whatever the mask holds. Class order is 0 chain completion, 1 node completion, 2 error A, 3 error B. The raw registers read at byte offsets 0x600, 0x608, 0x610 and 0x618 for classes 0 to 3.
- R3: A write to 0x018, 0x01C, 0x020 or 0x024 loads the mask of class 0, 1, 2 or 3. A 1 bit enables that channel. The register reads back the written value.
- R4: A read of 0x004, 0x008, 0x00C or 0x010 returns the raw bits AND the mask of class 0, 1, 2 or 3.
- R5: A read of 0x000 returns, for each channel, the OR over the four classes of that channel's masked bit.
- R6: A write to a raw register clears, in that class, exactly the channels whose data bit is 1. All other bits keep their value.
- R7: When an event sets a bit in the same cycle as a write that clears that same bit, the bit ends up set.
- R8: `irq_o` is high in the cycle after any combined-status bit is set, and low in the cycle after none is set.
- R9: A read request is answered in the following cycle, with `rd_vld_o` high for one cycle. Reads of unmapped offsets return zero. Writes to 0x000 and to the masked views change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld_i | input | 4 | Per-class event pulse |
| evt_ch_i | input | 4*CHW | Per-class channel index, CHW = clog2(NCH) |
| bus_vld_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | NCH | Write data |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | NCH | Read data |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The bench targets several corner cases.

- An event that collides with a clear of the same bit must survive. A design that gives the clear priority would lose the event and read back zero.
- An event on a disabled channel must still latch in the raw register but must not raise the interrupt. A design that gates the latch with the mask would lose it; one that forgets the mask would raise `irq_o`.
- The interrupt is checked on both edges: it stays low in the cycle the event latches, and it stays high for one cycle after the clear. An unregistered or doubly registered line shows up as a one-cycle shift.
- Writes to read-only and unmapped offsets are followed by read-backs. This catches loose decoding that would corrupt a mask or clear a raw bit.

// File: rtl/dia_pkg.sv
package dia_pkg;

    localparam int NCLS   = 4;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_ERRA  = 2'd2,
        CLS_ERRB  = 2'd3
    } evt_cls_e;

    localparam logic [ADDR_W-1:0] STAT_OFF = 12'h000;

    function automatic logic [ADDR_W-1:0] view_off(input int c);
        return ADDR_W'(32'h004 + 4 * c);
    endfunction

    function automatic logic [ADDR_W-1:0] mask_off(input int c);
        return ADDR_W'(32'h018 + 4 * c);
    endfunction

    function automatic logic [ADDR_W-1:0] raw_off(input int c);
        return ADDR_W'(32'h600 + 8 * c);
    endfunction

endpackage

// File: rtl/dia_evt_dec.sv
module dia_evt_dec
    import dia_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCLS-1:0]           vld_i,
    input  logic [NCLS-1:0][CHW-1:0]  idx_i,
    output logic [NCLS-1:0][NCH-1:0]  set_o
);

    // One-hot expansion of each class's tagged pulse
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            assign set_o[c][n] = vld_i[c] && (idx_i[c] == CHW'(n));
        end
    end

endmodule

// File: rtl/dia_class_bank.sv
module dia_class_bank #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    input  logic           mask_we_i,
    input  logic [NCH-1:0] mask_wd_i,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_o  <= '0;
            mask_o <= '0;
        end else begin
            // set applied after clear: a colliding event is kept
            raw_o <= (raw_o & ~clr_i) | set_i;
            if (mask_we_i)
                mask_o <= mask_wd_i;
        end
    end

endmodule

// File: rtl/dia_regif.sv
module dia_regif
    import dia_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_vld_i,
    input  logic                     bus_wr_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [NCH-1:0]           bus_wdata_i,
    input  logic [NCLS-1:0][NCH-1:0] raw_i,
    input  logic [NCLS-1:0][NCH-1:0] mask_i,
    input  logic [NCLS-1:0][NCH-1:0] view_i,
    input  logic [NCH-1:0]           comb_i,
    output logic [NCLS-1:0][NCH-1:0] clr_o,
    output logic [NCLS-1:0]          mask_we_o,
    output logic [NCH-1:0]           mask_wd_o,
    output logic                     rd_vld_o,
    output logic [NCH-1:0]           rd_data_o
);

    logic           wr_en;
    logic           rd_en;
    logic [NCH-1:0] rd_next;

    assign wr_en     = bus_vld_i && bus_wr_i;
    assign rd_en     = bus_vld_i && !bus_wr_i;
    assign mask_wd_o = bus_wdata_i;

    for (genvar c = 0; c < NCLS; c++) begin : g_wdec
        assign clr_o[c]     = (wr_en && bus_addr_i == raw_off(c)) ? bus_wdata_i : '0;
        assign mask_we_o[c] = wr_en && (bus_addr_i == mask_off(c));
    end

    always_comb begin
        rd_next = '0;
        if (bus_addr_i == STAT_OFF)
            rd_next = comb_i;
        for (int c = 0; c < NCLS; c++) begin
            if (bus_addr_i == view_off(c)) rd_next = view_i[c];
            if (bus_addr_i == mask_off(c)) rd_next = mask_i[c];
            if (bus_addr_i == raw_off(c))  rd_next = raw_i[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_o  <= 1'b0;
            rd_data_o <= '0;
        end else begin
            rd_vld_o <= rd_en;
            if (rd_en)
                rd_data_o <= rd_next;
        end
    end

endmodule

// File: rtl/dia_irq_agg.sv
module dia_irq_agg
    import dia_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCLS-1:0]           evt_vld_i,
    input  logic [NCLS-1:0][CHW-1:0]  evt_ch_i,
    input  logic                      bus_vld_i,
    input  logic                      bus_wr_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [NCH-1:0]            bus_wdata_i,
    output logic                      rd_vld_o,
    output logic [NCH-1:0]            rd_data_o,
    output logic                      irq_o
);

    logic [NCLS-1:0][NCH-1:0] set_vec;
    logic [NCLS-1:0][NCH-1:0] clr_vec;
    logic [NCLS-1:0][NCH-1:0] raw_q;
    logic [NCLS-1:0][NCH-1:0] mask_q;
    logic [NCLS-1:0][NCH-1:0] view;
    logic [NCLS-1:0]          mask_we;
    logic [NCH-1:0]           mask_wd;
    logic [NCH-1:0]           comb_stat;

    dia_evt_dec #(.NCH(NCH), .CHW(CHW)) u_dec (
        .vld_i (evt_vld_i),
        .idx_i (evt_ch_i),
        .set_o (set_vec)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_bank
        dia_class_bank #(.NCH(NCH)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .set_i     (set_vec[c]),
            .clr_i     (clr_vec[c]),
            .mask_we_i (mask_we[c]),
            .mask_wd_i (mask_wd),
            .raw_o     (raw_q[c]),
            .mask_o    (mask_q[c])
        );
        assign view[c] = raw_q[c] & mask_q[c];
    end

    always_comb begin
        comb_stat = '0;
        for (int c = 0; c < NCLS; c++)
            comb_stat = comb_stat | view[c];
    end

    dia_regif #(.NCH(NCH)) u_regif (
        .clk         (clk),
        .rst         (rst),
        .bus_vld_i   (bus_vld_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .raw_i       (raw_q),
        .mask_i      (mask_q),
        .view_i      (view),
        .comb_i      (comb_stat),
        .clr_o       (clr_vec),
        .mask_we_o   (mask_we),
        .mask_wd_o   (mask_wd),
        .rd_vld_o    (rd_vld_o),
        .rd_data_o   (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |comb_stat;
    end

endmodule

// File: rtl/dia_chk.sv
module dia_chk
    import dia_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = $clog2(NCH)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NCLS-1:0]           evt_vld_i,
    input logic [NCLS-1:0][CHW-1:0]  evt_ch_i,
    input logic                      bus_vld_i,
    input logic                      bus_wr_i,
    input logic [ADDR_W-1:0]         bus_addr_i,
    input logic [NCH-1:0]            bus_wdata_i,
    input logic                      rd_vld_o,
    input logic                      irq_o,
    input logic [NCLS-1:0][NCH-1:0]  raw_q,
    input logic [NCH-1:0]            comb_stat
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && !rd_vld_o));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|comb_stat) |=> irq_o);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|comb_stat) |=> !irq_o);

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_vld_i && !bus_wr_i) |=> rd_vld_o);

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_vld_i && !bus_wr_i) |=> !rd_vld_o);

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        // R2
        evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
            evt_vld_i[c] |=> raw_q[c][$past(evt_ch_i[c])]);

        // R6
        clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_vld_i && bus_wr_i && bus_addr_i == raw_off(c) && !evt_vld_i[c])
            |=> ((raw_q[c] & $past(bus_wdata_i)) == '0));
    end

endmodule

bind dia_irq_agg dia_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_vld_i   (evt_vld_i),
    .evt_ch_i    (evt_ch_i),
    .bus_vld_i   (bus_vld_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .rd_vld_o    (rd_vld_o),
    .irq_o       (irq_o),
    .raw_q       (raw_q),
    .comb_stat   (comb_stat)
);

// File: tb/sim_dia_irq_agg.sv
module sim_dia_irq_agg;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int CHW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [3:0]           evt_vld = '0;
    logic [3:0][CHW-1:0]  evt_ch = '0;
    logic                 bus_vld = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic [NCH-1:0]       bus_wdata = '0;
    logic                 rd_vld;
    logic [NCH-1:0]       rd_data;
    logic                 irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dia_irq_agg #(.NCH(NCH), .CHW(CHW)) u0 (
        .clk (clk), .rst (rst),
        .evt_vld_i (evt_vld), .evt_ch_i (evt_ch),
        .bus_vld_i (bus_vld), .bus_wr_i (bus_wr),
        .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
        .rd_vld_o (rd_vld), .rd_data_o (rd_data), .irq_o (irq)
    );

    // op: 0 = event (addr holds class, data holds channel), 1 = write, 2 = read and compare
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 12'h018, 16'hFFFF, 16'h0000, 4'd3},  // R3 enable all of class 0
        '{2'd2, 12'h018, 16'h0000, 16'hFFFF, 4'd3},  // R3
        '{2'd0, 12'h000, 16'd3,    16'h0000, 4'd2},  // R2 class 0 ch 3
        '{2'd2, 12'h600, 16'h0000, 16'h0008, 4'd2},  // R2
        '{2'd2, 12'h004, 16'h0000, 16'h0008, 4'd4},  // R4
        '{2'd2, 12'h000, 16'h0000, 16'h0008, 4'd5},  // R5
        '{2'd0, 12'h001, 16'd5,    16'h0000, 4'd2},  // R2 class 1 ch 5, masked
        '{2'd2, 12'h608, 16'h0000, 16'h0020, 4'd2},  // R2 latches despite mask
        '{2'd2, 12'h008, 16'h0000, 16'h0000, 4'd4},  // R4
        '{2'd2, 12'h000, 16'h0000, 16'h0008, 4'd5},  // R5
        '{2'd1, 12'h01C, 16'h0020, 16'h0000, 4'd3},  // R3
        '{2'd2, 12'h01C, 16'h0000, 16'h0020, 4'd3},  // R3
        '{2'd2, 12'h000, 16'h0000, 16'h0028, 4'd5},  // R5
        '{2'd0, 12'h002, 16'd15,   16'h0000, 4'd2},  // R2 class 2 ch 15
        '{2'd0, 12'h003, 16'd0,    16'h0000, 4'd2},  // R2 class 3 ch 0
        '{2'd1, 12'h020, 16'h8000, 16'h0000, 4'd3},  // R3
        '{2'd1, 12'h024, 16'h0001, 16'h0000, 4'd3},  // R3
        '{2'd2, 12'h00C, 16'h0000, 16'h8000, 4'd4},  // R4
        '{2'd2, 12'h010, 16'h0000, 16'h0001, 4'd4},  // R4
        '{2'd2, 12'h000, 16'h0000, 16'h8029, 4'd5},  // R5
        '{2'd1, 12'h600, 16'h0008, 16'h0000, 4'd6},  // R6 clear class 0 ch 3
        '{2'd2, 12'h600, 16'h0000, 16'h0000, 4'd6},  // R6
        '{2'd2, 12'h000, 16'h0000, 16'h8021, 4'd6},  // R6
        '{2'd1, 12'h004, 16'hFFFF, 16'h0000, 4'd9},  // R9 write to read-only view
        '{2'd1, 12'h000, 16'h0000, 16'h0000, 4'd9},  // R9 write to summary
        '{2'd2, 12'h018, 16'h0000, 16'hFFFF, 4'd9},  // R9 mask untouched
        '{2'd2, 12'h000, 16'h0000, 16'h8021, 4'd9},  // R9 status untouched
        '{2'd2, 12'h7FC, 16'h0000, 16'h0000, 4'd9},  // R9 unmapped reads zero
        '{2'd1, 12'h608, 16'hFFFF, 16'h0000, 4'd6},  // R6
        '{2'd2, 12'h608, 16'h0000, 16'h0000, 4'd6}   // R6
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_evt(input int cls, input int ch);
        @(negedge clk);
        evt_vld[cls] = 1'b1;
        evt_ch[cls]  = CHW'(ch);
        @(negedge clk);
        evt_vld = '0;
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic [11:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_vld = 1'b0;
        check(req, "rd_vld", {31'd0, rd_vld}, 32'd1);
        check(req, $sformatf("read %h", a), {16'd0, rd_data}, {16'd0, exp});
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "irq during reset", {31'd0, irq}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "rd_vld after reset", {31'd0, rd_vld}, 32'd0);
        check("R1", "rd_data after reset", {16'd0, rd_data}, 32'd0);
        do_rd("R1", 12'h000, 16'h0000);
        do_rd("R1", 12'h018, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_evt(int'(VEC[i].addr), int'(VEC[i].data));
                2'd1: do_wr(VEC[i].addr, VEC[i].data);
                default: do_rd($sformatf("R%0d", VEC[i].req), VEC[i].addr, VEC[i].exp);
            endcase
        end

        // clear remaining events; masks stay: c0 FFFF, c1 0020, c2 8000, c3 0001
        do_wr(12'h610, 16'hFFFF);
        do_wr(12'h618, 16'hFFFF);
        @(negedge clk);
        check("R8", "irq idle", {31'd0, irq}, 32'd0);

        // R8: registered interrupt edges
        @(negedge clk);
        evt_vld[0] = 1'b1; evt_ch[0] = 4'd2;
        @(negedge clk);
        evt_vld = '0;
        check("R8", "irq in latch cycle", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R8", "irq one cycle later", {31'd0, irq}, 32'd1);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = 12'h600; bus_wdata = 16'h0004;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
        check("R8", "irq in clear cycle", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R8", "irq after clear", {31'd0, irq}, 32'd0);

        // masked channel: latched but no interrupt
        do_evt(1, 0);
        @(negedge clk);
        check("R8", "irq for masked event", {31'd0, irq}, 32'd0);
        do_rd("R2", 12'h608, 16'h0001);
        do_rd("R5", 12'h000, 16'h0000);
        do_wr(12'h608, 16'h0001);

        // R7: event and clear of the same bit in one cycle
        do_evt(3, 4);
        @(negedge clk);
        evt_vld[3] = 1'b1; evt_ch[3] = 4'd0;
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = 12'h618; bus_wdata = 16'h0011;
        @(negedge clk);
        evt_vld = '0; bus_vld = 1'b0; bus_wr = 1'b0;
        do_rd("R7", 12'h618, 16'h0001);
        @(negedge clk);
        check("R7", "irq from surviving event", {31'd0, irq}, 32'd1);

        // R1: reset in mid-run clears masks, latches and irq
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "irq after second reset", {31'd0, irq}, 32'd0);
        do_rd("R1", 12'h018, 16'h0000);
        do_rd("R1", 12'h618, 16'h0000);

        done = 1'b1;
        report();
    end

endmodule